// File: doc/BRIEF.md
# Card Host Interrupt Status and Enable Unit

This unit holds the interrupt state of a card host controller. Event sources elsewhere in the controller raise one-cycle pulses, and each pulse sets a sticky bit in a status word. Software reads that word, acknowledges events by writing ones to the bits it wants cleared, and programs two masks. The first mask decides which events count. The second decides which of those events reach the interrupt line. One level-sensitive interrupt output is high while any event is set and passes both masks.

The error-summary bit in the status word is not stored. It is produced on the read path from the error half of the word. Some bits have protection. The card-interrupt status bit ignores software clears, and it is dropped only when its event-enable bit is written to zero. The out-of-band enable bit changes only while a control input from the surrounding register bank allows it.

The three registers share a small word address. Address 0 is status, address 1 is event-enable, address 2 is signal-enable, and address 3 is unused. Writes take effect at the clock edge. Read data and the interrupt output are combinational from the registers.

Top module: `card_irq_stat`

## Requirements
- R1: After reset, all three registers read zero and `irq` is low.
- R2: A pulse on a stored status position sets that bit at the next edge, and the bit stays set until it is cleared. The stored positions are 0, 1, 2, 4, 5, 8, 9, 16 to 22, 24, 28 and 29.
- R3: A write to address 0 clears every stored status bit whose data bit is one and leaves the other bits unchanged, except for the protected bits listed in R4.
- R4: The card-interrupt bit (position 8) ignores status writes. The error-summary bit (position 15) is not affected by writes either.
- R5: When a set pulse and a clear request from either source reach the same bit in the same cycle, the bit ends up set.
- R6: Bit 15 of the status read data is one exactly when a status bit in positions 31:16 is set. A pulse on position 15 has no effect.
- R7: Positions outside the stored set, and position 15, always read zero in all three registers, whatever is written or pulsed there.
- R8: A write to address 1 keeps the old out-of-band enable bit (position 9) unless `oob_en_ctl` is high during that write. All other bits take the written value.
- R9: A write to address 1 with bit 8 equal to zero also clears status bit 8.
- R10: `irq` is high exactly when some bit is set in status, event-enable and signal-enable at the same time. It follows register changes with no extra cycle.
- R11: Address 3 reads zero, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 event-enable, 2 signal-enable, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_pulse | input | 32 | One-cycle event pulses, one per status position |
| oob_en_ctl | input | 1 | Allows writes to the out-of-band enable bit |
| irq | output | 1 | Level interrupt request |

## Verification
Every write or pulse is sampled at one rising edge, and its effect on a register shows at that same edge. Read data and `irq` add no further register, so both are due in the cycle right after the stimulus. The bench applies one stimulus per clock. It waits 1 ns past the edge, then steps `reg_addr` through all four addresses, and compares each read and `irq` against a behavioural model that was advanced for that edge. The model is advanced once per clock, so a result that arrives one cycle early or late shows up as a mismatch on the next comparison.

// File: rtl/cis_pkg.sv
package cis_pkg;

  localparam int DW = 32;
  localparam int AW = 2;

  // status word layout
  localparam int B_CMD_DONE  = 0;
  localparam int B_XFER_DONE = 1;
  localparam int B_GAP       = 2;
  localparam int B_WR_RDY    = 4;
  localparam int B_RD_RDY    = 5;
  localparam int B_CARD_INT  = 8;
  localparam int B_OOB       = 9;
  localparam int B_ERR_SUM   = 15;
  localparam int B_CMD_TMO   = 16;
  localparam int B_CMD_CRC   = 17;
  localparam int B_CMD_END   = 18;
  localparam int B_CMD_IDX   = 19;
  localparam int B_DAT_TMO   = 20;
  localparam int B_DAT_CRC   = 21;
  localparam int B_DAT_END   = 22;
  localparam int B_ASTOP     = 24;
  localparam int B_CARD_ERR  = 28;
  localparam int B_BAD_ACC   = 29;
  localparam int ERR_LO      = 16;

  typedef logic [DW-1:0] word_t;

  localparam word_t ONE = word_t'(1);

  localparam word_t DEF_MASK =
      (ONE << B_CMD_DONE) | (ONE << B_XFER_DONE) | (ONE << B_GAP)     |
      (ONE << B_WR_RDY)   | (ONE << B_RD_RDY)    | (ONE << B_CARD_INT) |
      (ONE << B_OOB)      | (ONE << B_ERR_SUM)   | (ONE << B_CMD_TMO)  |
      (ONE << B_CMD_CRC)  | (ONE << B_CMD_END)   | (ONE << B_CMD_IDX)  |
      (ONE << B_DAT_TMO)  | (ONE << B_DAT_CRC)   | (ONE << B_DAT_END)  |
      (ONE << B_ASTOP)    | (ONE << B_CARD_ERR)  | (ONE << B_BAD_ACC);

  localparam word_t SUM_BIT  = ONE << B_ERR_SUM;
  localparam word_t CIRQ_BIT = ONE << B_CARD_INT;
  localparam word_t OOB_BIT  = ONE << B_OOB;
  localparam word_t KEEP_MASK = DEF_MASK & ~SUM_BIT;
  localparam word_t W1C_MASK  = KEEP_MASK & ~CIRQ_BIT;

  typedef enum logic [AW-1:0] {
    A_STAT  = 2'd0,
    A_EVEN  = 2'd1,
    A_SIGEN = 2'd2,
    A_NONE  = 2'd3
  } addr_e;

endpackage

// File: rtl/cis_status_reg.sv
module cis_status_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] stat_d;
  logic         upd;

  // set has priority over any clear on the same bit
  always_comb begin
    stat_d = ((stat_q & ~clr_vec) | set_vec) & KEEP;
    upd    = (|(set_vec & KEEP)) | (|(clr_vec & stat_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd) begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/cis_enable_reg.sv
module cis_enable_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '0,
  parameter logic [W-1:0] HOLD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         hold_ovr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);

  logic [W-1:0] hold_now;
  logic [W-1:0] en_d;

  always_comb begin
    hold_now = hold_ovr ? '0 : HOLD;
    en_d     = ((wdata & ~hold_now) | (en_q & hold_now)) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/cis_out_stage.sv
module cis_out_stage
  import cis_pkg::*;
#(
  parameter int W       = 32,
  parameter int SUM_POS = 15,
  parameter int LO      = 16
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  stat_q,
  input  logic [W-1:0]  ev_q,
  input  logic [W-1:0]  sg_q,
  output logic [W-1:0]  rdata,
  output logic          irq
);

  logic [W-1:0] stat_view;

  always_comb begin
    stat_view          = stat_q;
    stat_view[SUM_POS] = |stat_q[W-1:LO];
    case (addr_e'(rd_addr))
      A_STAT:  rdata = stat_view;
      A_EVEN:  rdata = ev_q;
      A_SIGEN: rdata = sg_q;
      default: rdata = '0;
    endcase
    irq = |(stat_q & ev_q & sg_q);
  end

endmodule

// File: rtl/card_irq_stat.sv
module card_irq_stat
  import cis_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] evt_pulse,
  input  logic          oob_en_ctl,
  output logic          irq
);

  localparam int NEN = 2;

  logic                    stat_wr;
  logic [DW-1:0]           clr_vec;
  logic [NEN-1:0]          en_wr;
  logic [NEN-1:0][DW-1:0]  en_arr;
  logic [DW-1:0]           stat_q;
  logic [DW-1:0]           ev_q;
  logic [DW-1:0]           sg_q;

  always_comb begin
    stat_wr = reg_wr && (reg_addr == A_STAT);
    clr_vec = stat_wr ? (reg_wdata & W1C_MASK) : '0;
    if (en_wr[0] && !reg_wdata[B_CARD_INT]) begin
      clr_vec = clr_vec | CIRQ_BIT;
    end
  end

  cis_status_reg #(
    .W    (DW),
    .KEEP (KEEP_MASK)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (evt_pulse),
    .clr_vec (clr_vec),
    .stat_q  (stat_q)
  );

  // index 0: event-enable (out-of-band bit protected), index 1: signal-enable
  for (genvar g = 0; g < NEN; g++) begin : g_en
    localparam addr_e SEL      = (g == 0) ? A_EVEN : A_SIGEN;
    localparam word_t HOLD_SEL = (g == 0) ? OOB_BIT : '0;

    assign en_wr[g] = reg_wr && (reg_addr == SEL);

    cis_enable_reg #(
      .W    (DW),
      .KEEP (KEEP_MASK),
      .HOLD (HOLD_SEL)
    ) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (en_wr[g]),
      .hold_ovr (oob_en_ctl),
      .wdata    (reg_wdata),
      .en_q     (en_arr[g])
    );
  end

  assign ev_q = en_arr[0];
  assign sg_q = en_arr[1];

  cis_out_stage #(
    .W       (DW),
    .SUM_POS (B_ERR_SUM),
    .LO      (ERR_LO)
  ) u_out (
    .rd_addr (reg_addr),
    .stat_q  (stat_q),
    .ev_q    (ev_q),
    .sg_q    (sg_q),
    .rdata   (reg_rdata),
    .irq     (irq)
  );

endmodule

// File: rtl/cis_chk.sv
module cis_chk
  import cis_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] evt_pulse,
  input logic          oob_en_ctl,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] ev_q,
  input logic [DW-1:0] sg_q,
  input logic          irq
);

  // R2
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_pulse & KEEP_MASK)) |=>
      ((stat_q & $past(evt_pulse & KEEP_MASK)) == $past(evt_pulse & KEEP_MASK)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT) |=>
      ((stat_q & $past(reg_wdata & W1C_MASK & ~evt_pulse)) == '0));

  // R4
  cirq_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && !evt_pulse[B_CARD_INT]) |=>
      (stat_q[B_CARD_INT] == $past(stat_q[B_CARD_INT])));

  // R7
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | ev_q | sg_q) & ~KEEP_MASK) == '0);

  // R8
  oob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EVEN && !oob_en_ctl) |=> $stable(ev_q[B_OOB]));

  // R9
  cirq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EVEN && !reg_wdata[B_CARD_INT] &&
     !evt_pulse[B_CARD_INT]) |=> !stat_q[B_CARD_INT]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_q == '0 || ev_q == '0) |-> !irq);

  // R11
  void_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_NONE && evt_pulse == '0) |=>
      ($stable(stat_q) && $stable(ev_q) && $stable(sg_q)));

endmodule

bind card_irq_stat cis_chk u_cis_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .evt_pulse  (evt_pulse),
  .oob_en_ctl (oob_en_ctl),
  .stat_q     (stat_q),
  .ev_q       (ev_q),
  .sg_q       (sg_q),
  .irq        (irq)
);

// File: tb/test_card_irq_stat.sv
`timescale 1ns/100ps
module test_card_irq_stat;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] evt_pulse;
  logic        oob_en_ctl;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_ie   = '0;
  logic [31:0] m_se   = '0;
  logic [31:0] lf     = 32'h1D2C_3B4A;

  always #2 clk = ~clk;

  card_irq_stat i_card_irq_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .evt_pulse  (evt_pulse),
    .oob_en_ctl (oob_en_ctl),
    .irq        (irq)
  );

  function automatic bit is_kept(int b);
    case (b)
      0, 1, 2, 4, 5, 8, 9, 16, 17, 18, 19, 20, 21, 22, 24, 28, 29: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int k);
    logic [31:0] v;
    case (k)
      0: begin
        v = m_stat;
        v[15] = (m_stat[31:16] != 16'h0);
      end
      1: v = m_ie;
      2: v = m_se;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_update(input bit wr, input logic [1:0] a,
                              input logic [31:0] d, input logic [31:0] ev,
                              input bit oob);
    logic [31:0] n_stat, n_ie, n_se;
    n_ie = m_ie;
    n_se = m_se;
    for (int b = 0; b < 32; b++) begin
      bit clr;
      clr = 1'b0;
      if (wr && a == 2'd0 && d[b] && b != 8 && b != 15) clr = 1'b1;
      if (wr && a == 2'd1) begin
        if (b == 9 && !oob) n_ie[b] = m_ie[b];
        else                n_ie[b] = is_kept(b) & d[b];
        if (b == 8 && !d[8]) clr = 1'b1;
      end
      if (wr && a == 2'd2) n_se[b] = is_kept(b) & d[b];
      n_stat[b] = is_kept(b) && (ev[b] || (m_stat[b] && !clr));
    end
    m_stat = n_stat;
    m_ie   = n_ie;
    m_se   = n_se;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] e;
    bit          ei;
    for (int k = 0; k < 4; k++) begin
      reg_addr = 2'(k);
      #0.2;
      e = exp_read(k);
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s addr %0d: actual %h expected %h", tag, k, reg_rdata, e);
      end
    end
    ei = ((m_stat & m_ie & m_se) != 32'h0);
    checks++;
    if (irq !== ei) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, ei);
    end
  endtask

  task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                      input logic [31:0] ev, input bit oob, input string tag);
    reg_wr     = wr;
    reg_addr   = a;
    reg_wdata  = d;
    evt_pulse  = ev;
    oob_en_ctl = oob;
    @(posedge clk);
    model_update(wr, a, d, ev, oob);
    #1;
    reg_wr     = 1'b0;
    reg_wdata  = '0;
    evt_pulse  = '0;
    oob_en_ctl = 1'b0;
    check_all(tag);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_pulse = '0; oob_en_ctl = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check_all("R1");

    step(0, 2'd0, 32'h0, 32'h0000_0003, 0, "R2");
    step(0, 2'd0, 32'h0, 32'h0,         0, "R2");
    step(0, 2'd0, 32'h0, 32'hC000_04C8, 0, "R7");
    step(0, 2'd0, 32'h0, 32'h0000_8000, 0, "R6");
    step(1, 2'd1, 32'hFFFF_FFFF, 32'h0, 0, "R8");
    step(1, 2'd2, 32'h0000_0001, 32'h0, 0, "R10");
    step(1, 2'd0, 32'h0000_0001, 32'h0, 0, "R3");
    step(1, 2'd1, 32'h0000_0200, 32'h0, 1, "R8");
    step(1, 2'd1, 32'h0000_0000, 32'h0, 0, "R8");
    step(0, 2'd0, 32'h0, 32'h0001_0000, 0, "R6");
    step(0, 2'd0, 32'h0, 32'h2000_0000, 0, "R6");
    step(1, 2'd0, 32'h0001_0000, 32'h0, 0, "R3");
    step(1, 2'd0, 32'h2000_0000, 32'h0, 0, "R6");
    step(1, 2'd1, 32'h0000_0100, 32'h0, 0, "R9");
    step(0, 2'd0, 32'h0, 32'h0000_0100, 0, "R2");
    step(1, 2'd0, 32'hFFFF_FFFF, 32'h0, 0, "R4");
    step(1, 2'd1, 32'h0000_0000, 32'h0, 0, "R9");
    step(0, 2'd0, 32'h0, 32'h0000_0002, 0, "R2");
    step(1, 2'd0, 32'h0000_0002, 32'h0000_0002, 0, "R5");
    step(1, 2'd1, 32'h0000_0100, 32'h0, 0, "R5");
    step(1, 2'd1, 32'h0000_0000, 32'h0000_0100, 0, "R5");
    step(1, 2'd3, 32'hFFFF_FFFF, 32'h0, 1, "R11");
    step(1, 2'd2, 32'hFFFF_FFFF, 32'h0, 0, "R10");
    step(1, 2'd1, 32'h0001_0000, 32'h0, 0, "R10");
    step(0, 2'd0, 32'h0, 32'h0001_0000, 0, "R10");
    step(1, 2'd2, 32'h0000_0000, 32'h0, 0, "R10");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r1, r2, r3;
      lf = nxt(lf); r1 = lf;
      lf = nxt(lf); r2 = lf;
      lf = nxt(lf); r3 = lf;
      step(r1[0], r1[2:1], r2, r3 & r2 & r1, r1[5], "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule